// File: doc/BRIEF.md
# Dual Interval Timer Peripheral

This peripheral places two independent down-counting interval timers behind a single 4 KB register window. Each 32-byte slice at the bottom of the window belongs to one timer. Reads and writes in a slice reach that timer's registers, with the slice base removed from the offset. The top eight words of the window form a read-only identification area. Every other offset, the two integration-test words included, reads as zero, and writes that fall outside the timer slices have no effect.

Each timer has its own tick-enable input, so software can clock the two timers at different rates. A timer decrements once per prescaled tick. It can run free, reload periodically from a limit, or stop after one expiry. Each timer drives its own masked interrupt line. The two lines are also ORed into one combined output.

The register port is a simple single-cycle interface. Writes take effect on the clock edge at which `req_i` and `we_i` are high. Read data is combinational from the current state while `req_i` is high, and zero otherwise.

Top module: `dual_tmr`

## Requirements
- R1: After reset each timer's control register reads 0x20 (interrupt mask enabled, timer stopped), its limit and count read 0, and all three interrupt outputs are low.
- R2: Byte offsets 0x00-0x1F address timer 0 and offsets 0x20-0x3F address timer 1, with 0x20 removed. Within a slice the registers sit at these offsets: 0x00 limit (a write also loads the count), 0x04 count (read only), 0x08 control, 0x0C interrupt clear (write only), 0x10 raw interrupt, 0x14 masked interrupt, and 0x18 limit without count load. A write to one slice leaves the other timer unchanged.
- R3: Reads of word offsets 0xFE0, 0xFE4 up to 0xFFC return bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, in bits 7:0, with bits 31:8 zero.
- R4: Offsets 0xF00 and 0xF04 and every other unmapped offset read 0. Writes outside 0x00-0x3F change no timer state. Writes to the count register are also ignored.
- R5: The control bits are: bit 7 run, bit 6 periodic, bit 5 interrupt mask enable, bits 3:2 prescale select, bit 1 32-bit width, and bit 0 single-shot. In periodic mode each step decrements the count. A step taken at count 0 sets the raw interrupt and reloads the limit, so the period is limit+1 steps.
- R6: A write to the interrupt-clear register clears the raw interrupt. When the mask enable bit is 0, the raw interrupt still sets, but the masked read and the timer's interrupt line stay 0.
- R7: The combined interrupt is high exactly when either timer's interrupt line is high.
- R8: Prescale select 0 steps on every tick, 1 on every 16th tick, and 2 on every 256th tick. Value 3 acts like 0. A control write restarts the prescaler.
- R9: In single-shot mode (bit 0 set, which takes priority over bit 6), a step at count 0 sets the raw interrupt, clears the run bit and leaves the count at 0.
- R10: With bits 0 and 6 both clear (free running), a step at count 0 wraps the count to 0xFFFF in 16-bit width or to 0xFFFFFFFF in 32-bit width, and sets the raw interrupt.
- R11: A write to offset 0x18 updates the limit, which both limit offsets read back, and leaves the running count unchanged. The new limit is used at the next reload.
- R12: A timer steps only on edges where its own tick input is high. Ticks given to the other timer do not move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 12 | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, zero when no request |
| tick_i | input | 2 | Per-timer count enable, bit n for timer n |
| irq0_o | output | 1 | Timer 0 masked interrupt |
| irq1_o | output | 1 | Timer 1 masked interrupt |
| irq_o | output | 1 | OR of both timer interrupts |

## Verification
The hardest cases to reach are the /16 prescale boundary and the one-shot expiry. In both, the observable change happens on one exact tick after a long run of ticks. The bench stops the tick inputs while it configures a timer. It then gives an exact number of tick-high edges and reads the count just before and just after the step it expects. Ticking each timer on its own input while reading the other timer's count shows that the two timers stay apart. Writing a limit through the background offset and then running to a reload shows the deferred effect of that write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int WIN_AW = 5;  // bytes per timer slice = 2**WIN_AW

  // word index inside a slice
  localparam logic [2:0] W_LIM  = 3'd0;
  localparam logic [2:0] W_CNT  = 3'd1;
  localparam logic [2:0] W_CTL  = 3'd2;
  localparam logic [2:0] W_CLR  = 3'd3;
  localparam logic [2:0] W_RAW  = 3'd4;
  localparam logic [2:0] W_MSK  = 3'd5;
  localparam logic [2:0] W_BGL  = 3'd6;

  // control bit positions
  localparam int C_ONE  = 0;
  localparam int C_WIDE = 1;
  localparam int C_PSL  = 2;
  localparam int C_IE   = 5;
  localparam int C_PER  = 6;
  localparam int C_RUN  = 7;

  localparam logic [7:0] CTL_RST = 8'h20;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h04;
      3'd1: id_byte = 8'h18;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       tick_i,
  input  logic [1:0] sel_i,
  output logic       step_o
);
  localparam logic [PRE_W-1:0] LIM16  = PRE_W'(15);
  localparam logic [PRE_W-1:0] LIM256 = PRE_W'(255);

  logic [PRE_W-1:0] cnt_q, lim;

  always_comb begin
    case (sel_i)
      2'd1:    lim = LIM16;
      2'd2:    lim = LIM256;
      default: lim = '0;
    endcase
  end

  assign step_o = tick_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan import tmr_pkg::*; #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [2:0]       wix_i,
  input  logic [31:0]      wdata_i,
  input  logic             tick_i,
  output logic [31:0]      rdata_o,
  output logic             irq_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o
);
  localparam logic [CNT_W-1:0] MASK16 = CNT_W'(17'h0FFFF);

  logic [7:0]       ctl_q;
  logic [CNT_W-1:0] lim_q, cnt_q, mask, cnt_eff;
  logic             raw_q, step, expire;

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_i && wix_i == W_CTL),
    .tick_i (tick_i && ctl_q[C_RUN]),
    .sel_i  (ctl_q[C_PSL +: 2]),
    .step_o (step)
  );

  assign mask    = ctl_q[C_WIDE] ? '1 : MASK16;
  assign cnt_eff = cnt_q & mask;
  assign expire  = step && (cnt_eff == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= CTL_RST;
      lim_q <= '0;
      cnt_q <= '0;
      raw_q <= 1'b0;
    end else begin
      if (expire) begin
        raw_q <= 1'b1;
        if (ctl_q[C_ONE])      ctl_q[C_RUN] <= 1'b0;
        else if (ctl_q[C_PER]) cnt_q <= lim_q & mask;
        else                   cnt_q <= mask;
      end else if (step) begin
        cnt_q <= (cnt_eff - 1'b1) & mask;
      end
      // register writes override the step, except that a set interrupt wins over clear
      if (wr_i) begin
        case (wix_i)
          W_LIM: begin
            lim_q <= wdata_i[CNT_W-1:0];
            cnt_q <= wdata_i[CNT_W-1:0];
          end
          W_BGL:   lim_q <= wdata_i[CNT_W-1:0];
          W_CTL:   ctl_q <= wdata_i[7:0];
          W_CLR:   if (!expire) raw_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (wix_i)
      W_LIM, W_BGL: rdata_o = 32'(lim_q);
      W_CNT:        rdata_o = 32'(cnt_eff);
      W_CTL:        rdata_o = {24'd0, ctl_q};
      W_RAW:        rdata_o = {31'd0, raw_q};
      W_MSK:        rdata_o = {31'd0, raw_q & ctl_q[C_IE]};
      default:      rdata_o = '0;
    endcase
  end

  assign irq_o = raw_q & ctl_q[C_IE];
  assign cnt_o = cnt_eff;
  assign lim_o = lim_q;
endmodule

// File: rtl/tmr_id_rom.sv
module tmr_id_rom import tmr_pkg::*; (
  input  logic [2:0]  idx_i,
  output logic [31:0] data_o
);
  assign data_o = {24'd0, id_byte(idx_i)};
endmodule

// File: rtl/dual_tmr.sv
module dual_tmr import tmr_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [1:0]        tick_i,
  output logic              irq0_o,
  output logic              irq1_o,
  output logic              irq_o
);
  localparam int SEL_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int UPPER_W = ADDR_W - WIN_AW;

  logic [UPPER_W-1:0]          slice;
  logic                        win_hit, id_hit;
  logic [SEL_W-1:0]            ch_sel;
  logic [NUM_CH-1:0][31:0]     ch_rd;
  logic [NUM_CH-1:0]           ch_irq;
  logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt, ch_lim;
  logic [31:0]                 id_rd;

  assign slice   = addr_i[ADDR_W-1:WIN_AW];
  assign win_hit = slice < UPPER_W'(NUM_CH);
  assign id_hit  = slice == '1;
  assign ch_sel  = SEL_W'(slice);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_chan #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (req_i && we_i && win_hit && ch_sel == SEL_W'(c)),
      .wix_i   (addr_i[WIN_AW-1:2]),
      .wdata_i (wdata_i),
      .tick_i  (tick_i[c]),
      .rdata_o (ch_rd[c]),
      .irq_o   (ch_irq[c]),
      .cnt_o   (ch_cnt[c]),
      .lim_o   (ch_lim[c])
    );
  end

  tmr_id_rom u_id (
    .idx_i  (addr_i[WIN_AW-1:2]),
    .data_o (id_rd)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (win_hit)     rdata_o = ch_rd[ch_sel];
      else if (id_hit) rdata_o = id_rd;
    end
  end

  assign irq0_o = ch_irq[0];
  assign irq1_o = ch_irq[NUM_CH-1];
  assign irq_o  = |ch_irq;
endmodule

// File: rtl/dual_tmr_chk.sv
module dual_tmr_chk #(
  parameter int ADDR_W = 12,
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         req_i,
  input logic                         we_i,
  input logic [ADDR_W-1:0]            addr_i,
  input logic [1:0]                   tick_i,
  input logic [31:0]                  rdata_o,
  input logic                         irq0_o,
  input logic                         irq1_o,
  input logic                         irq_o,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_lim
);
  logic wr, wr_ch0, wr_out;
  assign wr     = req_i && we_i;
  assign wr_ch0 = wr && addr_i[ADDR_W-1:5] == '0;
  assign wr_out = wr && addr_i[ADDR_W-1:6] != '0;

  p_id_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[ADDR_W-1:5] == '1) |-> rdata_o[31:8] == '0);

  p_test_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i == ADDR_W'(12'hF00) || addr_i == ADDR_W'(12'hF04))) |-> rdata_o == '0);

  p_ignore_wr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_out |=> $stable(ch_lim));

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(12'h00C) && !tick_i[0]) |=> !irq0_o);

  p_or_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq0_o || irq1_o));

  p_or_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq0_o || irq1_o) |-> irq_o);

  p_bgload_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(12'h018) && !tick_i[0]) |=> $stable(ch_cnt[0]));

  p_no_tick_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i[0] && !wr_ch0) |=> $stable(ch_cnt[0]));
endmodule

bind dual_tmr dual_tmr_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .tick_i  (tick_i),
  .rdata_o (rdata_o),
  .irq0_o  (irq0_o),
  .irq1_o  (irq1_o),
  .irq_o   (irq_o),
  .ch_cnt  (ch_cnt),
  .ch_lim  (ch_lim)
);

// File: tb/sim_dual_tmr.sv
module sim_dual_tmr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [1:0]  tick_i = '0;
  logic        irq0_o, irq1_o, irq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  dual_tmr u0 (.*);

  // {is_id, addr, expected}
  localparam logic [44:0] VEC [15] = '{
    {1'b1, 12'hFE0, 32'h04}, {1'b1, 12'hFE4, 32'h18}, {1'b1, 12'hFE8, 32'h14},
    {1'b1, 12'hFEC, 32'h00}, {1'b1, 12'hFF0, 32'h0D}, {1'b1, 12'hFF4, 32'hF0},
    {1'b1, 12'hFF8, 32'h05}, {1'b1, 12'hFFC, 32'hB1},
    {1'b0, 12'hF00, 32'h0},  {1'b0, 12'hF04, 32'h0},  {1'b0, 12'h040, 32'h0},
    {1'b0, 12'h100, 32'h0},  {1'b0, 12'hFDC, 32'h0},  {1'b0, 12'h03C, 32'h0},
    {1'b0, 12'h00C, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic run(input int ch, input int n);
    @(negedge clk_i);
    tick_i[ch] = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i[ch] = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(12'h008, v); chk("R1 ctl0", v, 32'h20);
    rd(12'h028, v); chk("R1 ctl1", v, 32'h20);
    rd(12'h000, v); chk("R1 lim0", v, 0);
    rd(12'h004, v); chk("R1 cnt0", v, 0);
    chk("R1 irq", {irq_o, irq1_o, irq0_o}, 0);

    // R3 / R4 table walk
    for (int i = 0; i < 15; i++) begin
      rd(VEC[i][43:32], v);
      chk(VEC[i][44] ? "R3 id" : "R4 zero", v, VEC[i][31:0]);
    end

    // R5 periodic, limit 3
    wr(12'h000, 3); wr(12'h008, 32'hE0);
    run(0, 3);
    rd(12'h004, v); chk("R5 count at 0", v, 0);
    chk("R5 no irq yet", irq0_o, 0);
    run(0, 1);
    rd(12'h004, v); chk("R5 reload", v, 3);
    rd(12'h010, v); chk("R5 raw", v, 1);
    rd(12'h014, v); chk("R5 masked", v, 1);
    chk("R7 comb irq", irq_o, 1);

    // R6 clear and mask
    wr(12'h00C, 0);
    chk("R6 cleared", irq0_o, 0);
    wr(12'h008, 32'hC0);
    run(0, 4);
    rd(12'h010, v); chk("R6 raw unmasked", v, 1);
    rd(12'h014, v); chk("R6 masked off", v, 0);
    chk("R6 line low", irq0_o, 0);
    wr(12'h00C, 0);
    wr(12'h008, 0);

    // R7 / R12 timer 1 alone
    wr(12'h020, 1); wr(12'h028, 32'hE0);
    run(1, 2);
    chk("R7 irq1", irq1_o, 1);
    chk("R7 irq0 low", irq0_o, 0);
    chk("R7 comb", irq_o, 1);
    rd(12'h004, v); chk("R12 ch0 still", v, 3);
    wr(12'h02C, 0); wr(12'h028, 0);
    chk("R7 comb low", irq_o, 0);

    // R8 prescale /16
    wr(12'h000, 2); wr(12'h008, 32'hE4);
    run(0, 15);
    rd(12'h004, v); chk("R8 before step", v, 2);
    run(0, 1);
    rd(12'h004, v); chk("R8 after step", v, 1);
    wr(12'h008, 0);

    // R9 single-shot
    wr(12'h00C, 0); wr(12'h000, 1); wr(12'h008, 32'hA1);
    run(0, 2);
    rd(12'h008, v); chk("R9 run cleared", v, 32'h21);
    rd(12'h004, v); chk("R9 count 0", v, 0);
    chk("R9 irq", irq0_o, 1);
    wr(12'h00C, 0);
    run(0, 3);
    chk("R9 no second irq", irq0_o, 0);

    // R10 free running wraps
    wr(12'h000, 0); wr(12'h008, 32'h80);
    run(0, 1);
    rd(12'h004, v); chk("R10 wrap16", v, 32'hFFFF);
    rd(12'h010, v); chk("R10 raw", v, 1);
    wr(12'h008, 0); wr(12'h00C, 0); wr(12'h000, 0); wr(12'h008, 32'h82);
    run(0, 1);
    rd(12'h004, v); chk("R10 wrap32", v, 32'hFFFF_FFFF);
    wr(12'h008, 0); wr(12'h00C, 0);

    // R11 background load
    wr(12'h000, 5); wr(12'h018, 9);
    rd(12'h000, v); chk("R11 lim", v, 9);
    rd(12'h018, v); chk("R11 bglim", v, 9);
    rd(12'h004, v); chk("R11 count kept", v, 5);
    wr(12'h008, 32'hC0);
    run(0, 6);
    rd(12'h004, v); chk("R11 reload new", v, 9);
    wr(12'h008, 0);

    // R2 slice routing, R4 ignored writes
    wr(12'h020, 32'h1234);
    rd(12'h020, v); chk("R2 ch1 lim", v, 32'h1234);
    rd(12'h000, v); chk("R2 ch0 lim", v, 9);
    wr(12'h040, 32'hFFFF); wr(12'hF00, 32'hFFFF); wr(12'h004, 32'h77);
    rd(12'h000, v); chk("R4 ch0 lim", v, 9);
    rd(12'h020, v); chk("R4 ch1 lim", v, 32'h1234);
    rd(12'h004, v); chk("R4 count write", v, 9);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule